// File: doc/BRIEF.md
# Sleep Mode Controller

This block manages power for a small 8-bit CPU core. Software programs a control register with a sleep-enable bit and a 3-bit mode code. The CPU then pulses a sleep strobe. If the enable bit is set and the code names a defined mode, the controller halts the CPU and drops the clock-gate enables that belong to that mode. These enables cover four domains: CPU, I/O peripherals, ADC and oscillator.

The controller wakes when it sees a wake source that the chosen mode still accepts, or a reset request. It then counts a mode-dependent start-up delay. After that it holds the CPU for a fixed four-cycle halt with every clock running. Finally it releases the CPU with a one-cycle pulse. That pulse is `irq_go` for an interrupt wake. It is `rst_vec` when execution must restart from the reset vector.

No storage is ever cleared by the controller. The control register itself keeps its contents across a full sleep and wake cycle.

Top module: `slp_ctl`

## Requirements
- R1: The control register reads as {4'b0000, mode[2:0], enable}. The mode code is in bits 3..1 and the enable bit is in bit 0. Bits 7..4 always read 0 and ignore writes. After reset the whole register reads 0.
- R2: A sleep strobe while the enable bit is 0 has no effect. `cpu_halt` and `sleeping` stay 0 and every clock enable stays 1.
- R3: The reserved codes 011, 100, 101 and 111 make a strobe a no-op, even when the enable bit is 1. The CPU is not halted.
- R4: Code 000 (idle) stops only the CPU clock while asleep. `cpu_clk_en`=0 and `io_clk_en`=`adc_clk_en`=`osc_keep`=1.
- R5: Code 001 (ADC quiet) gates the CPU and I/O clocks while asleep. `adc_clk_en`=1 and `osc_keep`=1.
- R6: Code 010 (deep power-down) gates all four enables while asleep.
- R7: Code 110 (standby) gates CPU, I/O and ADC while asleep, but `osc_keep` stays 1.
- R8: Which sources wake the block depends on the mode. In idle, `irq_io`, `irq_adc` and `irq_async` all wake it. In ADC quiet, only `irq_adc` and `irq_async` wake it. In power-down and standby, only `irq_async` wakes it. A source that the mode rejects leaves the block asleep. `rst_req` wakes every mode.
- R9: The start-up delay that follows a wake lasts 0 cycles for idle and ADC quiet. It lasts `PD_START` cycles for power-down and `SB_START` cycles for standby.
- R10: After the start-up delay, `cpu_halt` stays 1 for exactly `HALT_CYC` (4) further cycles with all clock enables at 1. Then `cpu_halt` falls, and `irq_go` pulses for one cycle in the first running cycle.
- R11: If `rst_req` is seen at any point from the start of sleep to the end of the halt, the final pulse is `rst_vec` and not `irq_go`. `rst_req` while running has no effect.
- R12: `cpu_halt` is 1 from the cycle after the strobe is accepted until the halt ends. `sleeping` is 1 only until a wake is seen.
- R13: Hardware never changes the control register. The enable bit and the mode read back unchanged after a full sleep and wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| sleep_stb | input | 1 | Sleep instruction strobe from the CPU |
| irq_io | input | 1 | Enabled interrupt from an I/O-clocked source |
| irq_adc | input | 1 | Enabled interrupt from the ADC |
| irq_async | input | 1 | Enabled asynchronous wake interrupt |
| rst_req | input | 1 | Reset request arriving during sleep |
| cpu_clk_en | output | 1 | CPU clock-gate enable |
| io_clk_en | output | 1 | I/O peripheral clock-gate enable |
| adc_clk_en | output | 1 | ADC clock-gate enable |
| osc_keep | output | 1 | Oscillator keep-alive |
| cpu_halt | output | 1 | Holds the CPU |
| sleeping | output | 1 | Status: waiting for a wake source |
| irq_go | output | 1 | One-cycle release into the interrupt path |
| rst_vec | output | 1 | One-cycle release into the reset vector |

## Verification
The bench builds the controller with `PD_START`=9 and `SB_START`=3. With these values the full wake time for every mode is a few cycles, so it can be counted exactly. The expected times are 4, 4, 13 and 7 cycles.

The bench sweeps all eight mode codes with the enable bit both set and clear. For each sleeping mode it first tries every rejected wake source and then the accepted one. It also drives reset-request wakes in idle and in power-down, and checks that a reset request while running has no effect.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_SLEEP, ST_START, ST_HALT} slp_st_e;

  typedef struct packed {
    logic cpu;
    logic io;
    logic adc;
    logic osc;
  } gate_t;

  typedef struct packed {
    logic io;
    logic adc;
    logic asy;
  } wake_t;

  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] M_IDLE  = 3'b000;
  localparam logic [MODE_W-1:0] M_ADCQ  = 3'b001;
  localparam logic [MODE_W-1:0] M_PDOWN = 3'b010;
  localparam logic [MODE_W-1:0] M_STBY  = 3'b110;
endpackage

// File: rtl/slp_regs.sv
module slp_regs
  import slp_pkg::*;
#(
  parameter int CTL_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTL_W-1:0]  wr_data,
  output logic [CTL_W-1:0]  rd_data,
  output logic [MODE_W-1:0] mode,
  output logic              sen
);
  localparam int PAD_W = CTL_W - MODE_W - 1;

  logic [MODE_W-1:0] mode_q, mode_d;
  logic              sen_q, sen_d;
  logic              unused_hi;

  assign unused_hi = ^wr_data[CTL_W-1:MODE_W+1];

  always_comb begin
    mode_d = mode_q;
    sen_d  = sen_q;
    if (wr_en) begin
      mode_d = wr_data[MODE_W:1];
      sen_d  = wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      sen_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      sen_q  <= sen_d;
    end
  end

  assign rd_data = {{PAD_W{1'b0}}, mode_q, sen_q};
  assign mode    = mode_q;
  assign sen     = sen_q;
endmodule

// File: rtl/slp_mode_dec.sv
module slp_mode_dec
  import slp_pkg::*;
#(
  parameter int CW       = 15,
  parameter int PD_START = 16384,
  parameter int SB_START = 6
) (
  input  logic [MODE_W-1:0] mode,
  output logic              valid,
  output gate_t             gate,
  output logic [CW-1:0]     start_len,
  output wake_t             wake
);
  always_comb begin
    valid     = 1'b0;
    gate      = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};
    start_len = '0;
    wake      = '{io: 1'b0, adc: 1'b0, asy: 1'b0};
    unique case (mode)
      M_IDLE: begin
        valid = 1'b1;
        gate  = '{cpu: 1'b0, io: 1'b1, adc: 1'b1, osc: 1'b1};
        wake  = '{io: 1'b1, adc: 1'b1, asy: 1'b1};
      end
      M_ADCQ: begin
        valid = 1'b1;
        gate  = '{cpu: 1'b0, io: 1'b0, adc: 1'b1, osc: 1'b1};
        wake  = '{io: 1'b0, adc: 1'b1, asy: 1'b1};
      end
      M_PDOWN: begin
        valid     = 1'b1;
        gate      = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b0};
        start_len = CW'(PD_START);
        wake      = '{io: 1'b0, adc: 1'b0, asy: 1'b1};
      end
      M_STBY: begin
        valid     = 1'b1;
        gate      = '{cpu: 1'b0, io: 1'b0, adc: 1'b0, osc: 1'b1};
        start_len = CW'(SB_START);
        wake      = '{io: 1'b0, adc: 1'b0, asy: 1'b1};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_pkg::*;
#(
  parameter int CW       = 15,
  parameter int HALT_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              sen,
  input  logic [MODE_W-1:0] reg_mode,
  input  logic              valid,
  input  gate_t             gate,
  input  logic [CW-1:0]     start_len,
  input  wake_t             wake,
  input  logic              irq_io,
  input  logic              irq_adc,
  input  logic              irq_async,
  input  logic              rst_req,
  output logic [MODE_W-1:0] dec_mode,
  output gate_t             gate_out,
  output logic              cpu_halt,
  output logic              sleeping,
  output logic              irq_go,
  output logic              rst_vec
);
  localparam int HW = $clog2(HALT_CYC + 1);

  slp_st_e           st_q, st_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [HW-1:0]     hcnt_q, hcnt_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              rpath_q, rpath_d;
  logic              go_q, go_d;
  logic              rv_q, rv_d;
  logic              wake_hit;

  assign dec_mode = (st_q == ST_RUN) ? reg_mode : mode_q;
  assign wake_hit = rst_req | (irq_async & wake.asy) |
                    (irq_io & wake.io) | (irq_adc & wake.adc);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    hcnt_d  = hcnt_q;
    mode_d  = mode_q;
    rpath_d = rpath_q | ((st_q != ST_RUN) & rst_req);
    go_d    = 1'b0;
    rv_d    = 1'b0;
    unique case (st_q)
      ST_RUN: begin
        rpath_d = 1'b0;
        if (stb && sen && valid) begin
          st_d   = ST_SLEEP;
          mode_d = reg_mode;
        end
      end
      ST_SLEEP: begin
        if (wake_hit) begin
          if (start_len == '0) begin
            st_d   = ST_HALT;
            hcnt_d = HW'(HALT_CYC - 1);
          end else begin
            st_d  = ST_START;
            cnt_d = start_len - 1'b1;
          end
        end
      end
      ST_START: begin
        if (cnt_q == '0) begin
          st_d   = ST_HALT;
          hcnt_d = HW'(HALT_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HALT: begin
        if (hcnt_q == '0) begin
          st_d = ST_RUN;
          go_d = ~rpath_d;
          rv_d = rpath_d;
        end else begin
          hcnt_d = hcnt_q - 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      cnt_q   <= '0;
      hcnt_q  <= '0;
      mode_q  <= '0;
      rpath_q <= 1'b0;
      go_q    <= 1'b0;
      rv_q    <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      hcnt_q  <= hcnt_d;
      mode_q  <= mode_d;
      rpath_q <= rpath_d;
      go_q    <= go_d;
      rv_q    <= rv_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_SLEEP: gate_out = gate;
      ST_START: gate_out = '{cpu: gate.cpu, io: gate.io, adc: gate.adc, osc: 1'b1};
      default:  gate_out = '{cpu: 1'b1, io: 1'b1, adc: 1'b1, osc: 1'b1};
    endcase
  end

  assign cpu_halt = (st_q != ST_RUN);
  assign sleeping = (st_q == ST_SLEEP);
  assign irq_go   = go_q;
  assign rst_vec  = rv_q;
endmodule

// File: rtl/slp_ctl.sv
module slp_ctl
  import slp_pkg::*;
#(
  parameter int CTL_W    = 8,
  parameter int PD_START = 16384,
  parameter int SB_START = 6,
  parameter int HALT_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [CTL_W-1:0] reg_wdata,
  output logic [CTL_W-1:0] reg_rdata,
  input  logic             sleep_stb,
  input  logic             irq_io,
  input  logic             irq_adc,
  input  logic             irq_async,
  input  logic             rst_req,
  output logic             cpu_clk_en,
  output logic             io_clk_en,
  output logic             adc_clk_en,
  output logic             osc_keep,
  output logic             cpu_halt,
  output logic             sleeping,
  output logic             irq_go,
  output logic             rst_vec
);
  localparam int MAX_START = (PD_START > SB_START) ? PD_START : SB_START;
  localparam int CW        = $clog2(MAX_START + 2);

  logic [1:0]        rst_sync;
  logic              rst_ni;
  logic [MODE_W-1:0] reg_mode, dec_mode;
  logic              sen, valid;
  gate_t             gate, gate_out;
  wake_t             wake;
  logic [CW-1:0]     start_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  slp_regs #(.CTL_W(CTL_W)) i_regs (
    .clk(clk), .rst_n(rst_ni), .wr_en(reg_we), .wr_data(reg_wdata),
    .rd_data(reg_rdata), .mode(reg_mode), .sen(sen)
  );

  slp_mode_dec #(.CW(CW), .PD_START(PD_START), .SB_START(SB_START)) i_dec (
    .mode(dec_mode), .valid(valid), .gate(gate), .start_len(start_len), .wake(wake)
  );

  slp_seq #(.CW(CW), .HALT_CYC(HALT_CYC)) i_seq (
    .clk(clk), .rst_n(rst_ni), .stb(sleep_stb), .sen(sen), .reg_mode(reg_mode),
    .valid(valid), .gate(gate), .start_len(start_len), .wake(wake),
    .irq_io(irq_io), .irq_adc(irq_adc), .irq_async(irq_async), .rst_req(rst_req),
    .dec_mode(dec_mode), .gate_out(gate_out), .cpu_halt(cpu_halt),
    .sleeping(sleeping), .irq_go(irq_go), .rst_vec(rst_vec)
  );

  assign cpu_clk_en = gate_out.cpu;
  assign io_clk_en  = gate_out.io;
  assign adc_clk_en = gate_out.adc;
  assign osc_keep   = gate_out.osc;
endmodule

// File: rtl/slp_ctl_chk.sv
module slp_ctl_chk #(
  parameter int CTL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [CTL_W-1:0] reg_rdata,
  input logic             sleep_stb,
  input logic             irq_async,
  input logic             rst_req,
  input logic             cpu_clk_en,
  input logic             io_clk_en,
  input logic             adc_clk_en,
  input logic             osc_keep,
  input logic             cpu_halt,
  input logic             sleeping,
  input logic             irq_go,
  input logic             rst_vec
);
  p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[CTL_W-1:4] == '0);

  p_no_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_halt && sleep_stb && !reg_rdata[0]) |=> !cpu_halt);

  p_reserved_noop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_halt && sleep_stb && reg_rdata[0] &&
     (reg_rdata[3:1] == 3'b011 || reg_rdata[3:1] == 3'b100 ||
      reg_rdata[3:1] == 3'b101 || reg_rdata[3:1] == 3'b111)) |=> !cpu_halt);

  p_cpu_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> !cpu_clk_en);

  p_deep_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !osc_keep) |-> (!io_clk_en && !adc_clk_en));

  p_async_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !adc_clk_en && !irq_async && !rst_req) |=> sleeping);

  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_go |-> ($past(cpu_halt) && !cpu_halt && io_clk_en));

  p_one_path_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_go && rst_vec));

  p_halted_asleep_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sleeping |-> cpu_halt);

  p_reg_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> (reg_rdata == $past(reg_rdata)));
endmodule

bind slp_ctl slp_ctl_chk #(.CTL_W(CTL_W)) i_slp_ctl_chk (
  .clk(clk), .rst_n(rst_ni), .reg_we(reg_we), .reg_rdata(reg_rdata),
  .sleep_stb(sleep_stb), .irq_async(irq_async), .rst_req(rst_req),
  .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en), .adc_clk_en(adc_clk_en),
  .osc_keep(osc_keep), .cpu_halt(cpu_halt), .sleeping(sleeping),
  .irq_go(irq_go), .rst_vec(rst_vec)
);

// File: tb/test_slp_ctl.sv
`timescale 1ns/1ps
module test_slp_ctl;
  localparam int PD_S = 9;
  localparam int SB_S = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_we;
  logic [7:0] reg_wdata, reg_rdata;
  logic sleep_stb, irq_io, irq_adc, irq_async, rst_req;
  logic cpu_clk_en, io_clk_en, adc_clk_en, osc_keep;
  logic cpu_halt, sleeping, irq_go, rst_vec;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  slp_ctl #(.PD_START(PD_S), .SB_START(SB_S)) i_slp_ctl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sleep_stb(sleep_stb), .irq_io(irq_io),
    .irq_adc(irq_adc), .irq_async(irq_async), .rst_req(rst_req),
    .cpu_clk_en(cpu_clk_en), .io_clk_en(io_clk_en), .adc_clk_en(adc_clk_en),
    .osc_keep(osc_keep), .cpu_halt(cpu_halt), .sleeping(sleeping),
    .irq_go(irq_go), .rst_vec(rst_vec)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_valid(input logic [2:0] m);
    return (m == 3'b000 || m == 3'b001 || m == 3'b010 || m == 3'b110);
  endfunction

  // {cpu, io, adc, osc} while asleep
  function automatic logic [3:0] exp_gate(input logic [2:0] m);
    case (m)
      3'b000:  return 4'b0111;
      3'b001:  return 4'b0011;
      3'b010:  return 4'b0000;
      default: return 4'b0001;
    endcase
  endfunction

  function automatic int exp_start(input logic [2:0] m);
    if (m == 3'b010) return PD_S;
    if (m == 3'b110) return SB_S;
    return 0;
  endfunction

  task automatic wr(input logic [7:0] d);
    reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic strobe();
    sleep_stb = 1'b1;
    @(negedge clk);
    sleep_stb = 1'b0;
  endtask

  // src: 0 io, 1 adc, 2 async, 3 reset request
  task automatic pulse(input int src);
    irq_io    = (src == 0);
    irq_adc   = (src == 1);
    irq_async = (src == 2);
    rst_req   = (src == 3);
    @(negedge clk);
    irq_io = 1'b0; irq_adc = 1'b0; irq_async = 1'b0; rst_req = 1'b0;
  endtask

  task automatic count_halt(output int n);
    n = 0;
    while (cpu_halt && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_case(input logic [2:0] m, input logic se);
    logic [7:0] rd_exp;
    int n;
    int acc_src;
    wr({4'b1010, m, se});
    rd_exp = {4'b0000, m, se};
    chk(reg_rdata == rd_exp, "R1 readback", reg_rdata, rd_exp);
    strobe();
    if (!se) begin
      chk(!cpu_halt && !sleeping && {cpu_clk_en, io_clk_en, adc_clk_en, osc_keep} == 4'hF,
          "R2 strobe with enable clear", cpu_halt, 0);
    end else if (!is_valid(m)) begin
      chk(!cpu_halt && !sleeping, "R3 reserved code no-op", cpu_halt, 0);
    end else begin
      chk(cpu_halt && sleeping, "R12 halted after strobe", {cpu_halt, sleeping}, 3);
      chk({cpu_clk_en, io_clk_en, adc_clk_en, osc_keep} == exp_gate(m),
          (m == 3'b000) ? "R4 idle gating" : (m == 3'b001) ? "R5 adc quiet gating" :
          (m == 3'b010) ? "R6 power-down gating" : "R7 standby gating",
          {cpu_clk_en, io_clk_en, adc_clk_en, osc_keep}, exp_gate(m));
      // rejected sources
      if (m != 3'b000) begin
        pulse(0);
        chk(sleeping && cpu_halt, "R8 io interrupt rejected", sleeping, 1);
      end
      if (m == 3'b010 || m == 3'b110) begin
        pulse(1);
        chk(sleeping && cpu_halt, "R8 adc interrupt rejected", sleeping, 1);
      end
      acc_src = (m == 3'b000) ? 0 : (m == 3'b001) ? 1 : 2;
      pulse(acc_src);
      chk(!sleeping, "R8 accepted source wakes", sleeping, 0);
      count_halt(n);
      chk(n == exp_start(m) + 4, "R9 R10 wake time", n, exp_start(m) + 4);
      chk(irq_go && !rst_vec, "R10 interrupt release pulse", {irq_go, rst_vec}, 2);
      chk({cpu_clk_en, io_clk_en, adc_clk_en, osc_keep} == 4'hF, "R10 clocks on after wake",
          {cpu_clk_en, io_clk_en, adc_clk_en, osc_keep}, 15);
      @(negedge clk);
      chk(!irq_go, "R10 pulse one cycle", irq_go, 0);
      chk(reg_rdata == rd_exp, "R13 register kept", reg_rdata, rd_exp);
    end
    @(negedge clk);
  endtask

  initial begin
    int n;
    rst_n = 1'b0; reg_we = 1'b0; reg_wdata = '0; sleep_stb = 1'b0;
    irq_io = 1'b0; irq_adc = 1'b0; irq_async = 1'b0; rst_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(reg_rdata == 8'h00, "R1 reset value", reg_rdata, 0);
    chk(!cpu_halt && !sleeping && !irq_go && !rst_vec, "R12 reset outputs", cpu_halt, 0);
    chk({cpu_clk_en, io_clk_en, adc_clk_en, osc_keep} == 4'hF, "R2 reset clocks on",
        {cpu_clk_en, io_clk_en, adc_clk_en, osc_keep}, 15);

    for (int se = 0; se < 2; se++)
      for (int m = 0; m < 8; m++)
        run_case(3'(m), 1'(se));

    // reset request while running
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    chk(!cpu_halt && !rst_vec, "R11 reset request while running", {cpu_halt, rst_vec}, 0);

    // reset-request wake from idle
    wr(8'b0000_0001);
    strobe();
    pulse(3);
    count_halt(n);
    chk(n == 4, "R11 reset wake time idle", n, 4);
    chk(rst_vec && !irq_go, "R11 reset vector from idle", {irq_go, rst_vec}, 1);
    @(negedge clk);

    // interrupt and reset request together in power-down
    wr(8'b0000_0101);
    strobe();
    irq_async = 1'b1; rst_req = 1'b1;
    @(negedge clk);
    irq_async = 1'b0; rst_req = 1'b0;
    count_halt(n);
    chk(n == PD_S + 4, "R11 reset wake time power-down", n, PD_S + 4);
    chk(rst_vec && !irq_go, "R11 reset wins over interrupt", {irq_go, rst_vec}, 1);
    chk(reg_rdata == 8'h05, "R13 enable bit kept", reg_rdata, 5);
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule